// File: doc/BRIEF.md
# Rename History Buffer with Rollback and Retirement

This block keeps an ordered log of register renames made by an out-of-order core's rename stage. Each entry records the instruction's sequence number, the architectural register it writes, the physical register newly given to it, the physical register that held that architectural register before, and a flag that marks an entry standing in for an instruction with no destination. The rename stage appends entries in program order, one per cycle.

Two walks use the same log from opposite ends. A rollback walks back from the youngest entry after a misprediction. For each entry it undoes, it sends a map-table write that puts back the old mapping, and it returns the new physical register to the free list. A retirement walks forward from the oldest entry after instructions commit, and returns each superseded physical register to the free list. Both walks handle one entry per cycle and drive the map table and free list through single-operation command ports. Four event counters track placeholder appends, committed mappings, undone entries and undone entries that were real mappings.

Top module: `rename_history`

## Requirements
- R1: After reset, `full`, `busy`, `map_wr_valid` and `free_valid` are low and all four counters read zero.
- R2: An accepted append with `push_placeholder` high stores one entry that holds only its sequence number and adds one to `cnt_placeholder`. An accepted append with it low stores the architectural register, the new physical register and the previous physical register. An instruction with several destinations is appended as one entry per destination, all with the same sequence number.
- R3: A rollback request with target S removes entries youngest first, one per cycle, while the youngest entry's sequence number is greater than S. Entries with a sequence number of S or less stay in the buffer, and `busy` stays high until the walk ends.
- R4: Each real entry removed by a rollback produces, in the same cycle, `map_wr_valid` with (`map_wr_arch`, `map_wr_phys`) equal to its architectural register and previous physical register, and `free_valid` with `free_phys` equal to its new physical register. A placeholder entry removed this way produces neither command.
- R5: A retirement request with target C, taken while idle, removes entries oldest first, one per cycle, while the oldest sequence number is C or less. Each real entry drives `free_valid` with its previous physical register and never drives `map_wr_valid`. Placeholder entries are removed silently.
- R6: A retirement request is ignored when the buffer is empty or its oldest sequence number is greater than C. No command is issued, no counter changes, no entry is removed and `busy` stays low.
- R7: A rollback request on an empty buffer issues no command and changes no counter.
- R8: `cnt_committed` counts real entries freed by retirement. `cnt_undone` counts every entry a rollback removes. `cnt_undone_real` counts only the real ones. Each counter steps by at most one per cycle.
- R9: A rollback request takes priority over a retirement in progress. The retirement stops with no further removal, and the entries it had already removed stay removed.
- R10: `full` is high when the buffer holds DEPTH entries. An append while `full` is high, while a rollback is requested, or while a rollback is running is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Append one entry |
| push_placeholder | input | 1 | Entry has no destination register |
| push_seq | input | SEQ_W | Sequence number of the appended entry |
| push_arch | input | ARCH_W | Architectural destination register |
| push_new_phys | input | PHYS_W | Newly given physical register |
| push_old_phys | input | PHYS_W | Physical register previously mapped |
| squash_valid | input | 1 | Rollback request |
| squash_seq | input | SEQ_W | Youngest sequence number that survives |
| commit_valid | input | 1 | Retirement request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| map_wr_valid | output | 1 | Map-table restore command |
| map_wr_arch | output | ARCH_W | Architectural register to restore |
| map_wr_phys | output | PHYS_W | Physical register to restore |
| free_valid | output | 1 | Free-list return command |
| free_phys | output | PHYS_W | Physical register returned |
| full | output | 1 | Buffer holds DEPTH entries; rename must stall |
| busy | output | 1 | A rollback or retirement walk is running |
| cnt_placeholder | output | CNT_W | Placeholder appends |
| cnt_committed | output | CNT_W | Real entries freed by retirement |
| cnt_undone | output | CNT_W | Entries removed by rollback |
| cnt_undone_real | output | CNT_W | Real entries removed by rollback |

## Verification
The assertions that check where each walk stops assume that appended sequence numbers rise strictly, apart from repeats within one instruction. They also assume that nothing appended during a retirement carries a sequence number at or below its target. The bench keeps to this by using fixed, rising sequence numbers and by appending only while no walk is running, except for the deliberate append made in the same cycle as a rollback request. A reference queue in the bench predicts every command, its order and every counter value from the requirements.

// File: rtl/hb_pkg.sv
package hb_pkg;
    parameter int SEQ_W  = 16;
    parameter int ARCH_W = 5;
    parameter int PHYS_W = 7;

    typedef struct packed {
        logic              ph;
        logic [SEQ_W-1:0]  seq;
        logic [ARCH_W-1:0] arch;
        logic [PHYS_W-1:0] newp;
        logic [PHYS_W-1:0] oldp;
    } hb_rec_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_UNDO   = 2'd1,
        ST_RETIRE = 2'd2
    } hb_mode_e;

    // event bit positions towards the counter bank
    localparam int EV_PH      = 0;
    localparam int EV_COMMIT  = 1;
    localparam int EV_UNDO    = 2;
    localparam int EV_UNDO_RL = 3;
    localparam int EV_N       = 4;
endpackage

// File: rtl/hb_ring.sv
module hb_ring
    import hb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push_en,
    input  hb_rec_t push_rec,
    input  logic    pop_new,
    input  logic    pop_old,
    output hb_rec_t oldest,
    output hb_rec_t newest,
    output logic    full,
    output logic    empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = $clog2(DEPTH + 1);

    typedef struct packed {
        hb_rec_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]    wr;
        logic [PTR_W-1:0]    rd;
        logic [CW-1:0]       cnt;
    } ring_t;

    ring_t q, d;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    function automatic logic [PTR_W-1:0] prv(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_W'(DEPTH - 1) : p - PTR_W'(1);
    endfunction

    logic do_push, do_pop_old, do_pop_new;

    assign full   = (q.cnt == CW'(DEPTH));
    assign empty  = (q.cnt == '0);
    assign oldest = q.mem[q.rd];
    assign newest = q.mem[prv(q.wr)];

    always_comb begin
        d          = q;
        do_push    = push_en && !full;
        do_pop_old = pop_old && !empty;
        do_pop_new = pop_new && !empty && !do_pop_old;
        if (do_pop_old) begin
            d.rd = nxt(q.rd);
        end
        if (do_pop_new) begin
            d.wr = prv(q.wr);
        end
        if (do_push && !do_pop_new) begin
            d.mem[q.wr] = push_rec;
            d.wr        = nxt(q.wr);
        end
        d.cnt = q.cnt
              + CW'(do_push && !do_pop_new)
              - CW'(do_pop_old || do_pop_new);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R10: occupancy never exceeds the storage
    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));

    // R10: a full buffer stays full while nothing is removed
    a_r10_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop_old && !pop_new) |=> full);

    // R3: the two walks never remove from both ends in one cycle
    a_r3_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_old && pop_new));
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
    import hb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic              push_placeholder,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              full,
    input  logic              empty,
    input  hb_rec_t           oldest,
    input  hb_rec_t           newest,
    output logic              push_en,
    output logic              pop_new,
    output logic              pop_old,
    output logic              busy,
    output logic              map_wr_valid,
    output logic [ARCH_W-1:0] map_wr_arch,
    output logic [PHYS_W-1:0] map_wr_phys,
    output logic              free_valid,
    output logic [PHYS_W-1:0] free_phys,
    output logic [EV_N-1:0]   events
);
    typedef struct packed {
        hb_mode_e          mode;
        logic [SEQ_W-1:0]  tgt;
        logic              map_v;
        logic [ARCH_W-1:0] map_arch;
        logic [PHYS_W-1:0] map_phys;
        logic              free_v;
        logic [PHYS_W-1:0] free_phys;
        logic [EV_N-1:0]   ev;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d        = q;
        d.map_v  = 1'b0;
        d.free_v = 1'b0;
        d.ev     = '0;
        pop_new  = 1'b0;
        pop_old  = 1'b0;
        push_en  = push_valid && !full && !squash_valid && (q.mode != ST_UNDO);
        d.ev[EV_PH] = push_en && push_placeholder;

        if (squash_valid) begin
            // rollback wins over everything, including a retirement walk
            d.mode = ST_UNDO;
            d.tgt  = squash_seq;
        end else begin
            unique case (q.mode)
                ST_IDLE: begin
                    if (commit_valid && !empty && (oldest.seq <= commit_seq)) begin
                        d.mode = ST_RETIRE;
                        d.tgt  = commit_seq;
                    end
                end
                ST_UNDO: begin
                    if (!empty && (newest.seq > q.tgt)) begin
                        pop_new         = 1'b1;
                        d.ev[EV_UNDO]   = 1'b1;
                        if (!newest.ph) begin
                            d.map_v        = 1'b1;
                            d.map_arch     = newest.arch;
                            d.map_phys     = newest.oldp;
                            d.free_v       = 1'b1;
                            d.free_phys    = newest.newp;
                            d.ev[EV_UNDO_RL] = 1'b1;
                        end
                    end else begin
                        d.mode = ST_IDLE;
                    end
                end
                ST_RETIRE: begin
                    if (!empty && (oldest.seq <= q.tgt)) begin
                        pop_old = 1'b1;
                        if (!oldest.ph) begin
                            d.free_v        = 1'b1;
                            d.free_phys     = oldest.oldp;
                            d.ev[EV_COMMIT] = 1'b1;
                        end
                    end else begin
                        d.mode = ST_IDLE;
                    end
                end
                default: d.mode = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy         = (q.mode != ST_IDLE);
    assign map_wr_valid = q.map_v;
    assign map_wr_arch  = q.map_arch;
    assign map_wr_phys  = q.map_phys;
    assign free_valid   = q.free_v;
    assign free_phys    = q.free_phys;
    assign events       = q.ev;

    // R4: map restores come only out of a rollback walk
    a_r4_map_from_undo: assert property (@(posedge clk) disable iff (!rst_n)
        map_wr_valid |-> $past(q.mode == ST_UNDO));

    // R5: every free command comes out of one of the two walks
    a_r5_free_from_walk: assert property (@(posedge clk) disable iff (!rst_n)
        free_valid |-> $past(q.mode != ST_IDLE));

    // R3: a finished rollback leaves nothing younger than its target
    a_r3_undo_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.mode == ST_IDLE) && $past(q.mode == ST_UNDO))
            |-> (empty || (newest.seq <= q.tgt)));

    // R5: a finished retirement leaves nothing at or below its target
    a_r5_retire_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.mode == ST_IDLE) && $past(q.mode == ST_RETIRE))
            |-> (empty || (oldest.seq > q.tgt)));

    // R9: a rollback request always puts the walker into rollback next
    a_r9_undo_wins: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |=> (q.mode == ST_UNDO));
endmodule

// File: rtl/hb_counters.sv
module hb_counters
    import hb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [EV_N-1:0]             events,
    output logic [EV_N-1:0][CNT_W-1:0]  counts
);
    typedef struct packed {
        logic [EV_N-1:0][CNT_W-1:0] c;
    } cnt_t;

    cnt_t q, d;

    always_comb begin
        d = q;
        for (int i = 0; i < EV_N; i++) begin
            if (events[i]) begin
                d.c[i] = q.c[i] + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign counts = q.c;

    for (genvar g = 0; g < EV_N; g++) begin : g_chk
        // R8: each counter moves by zero or one per cycle
        a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
            (q.c[g] == $past(q.c[g])) || (q.c[g] == $past(q.c[g]) + CNT_W'(1)));
    end
endmodule

// File: rtl/rename_history.sv
module rename_history
    import hb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic              push_placeholder,
    input  logic [SEQ_W-1:0]  push_seq,
    input  logic [ARCH_W-1:0] push_arch,
    input  logic [PHYS_W-1:0] push_new_phys,
    input  logic [PHYS_W-1:0] push_old_phys,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    output logic              map_wr_valid,
    output logic [ARCH_W-1:0] map_wr_arch,
    output logic [PHYS_W-1:0] map_wr_phys,
    output logic              free_valid,
    output logic [PHYS_W-1:0] free_phys,
    output logic              full,
    output logic              busy,
    output logic [CNT_W-1:0]  cnt_placeholder,
    output logic [CNT_W-1:0]  cnt_committed,
    output logic [CNT_W-1:0]  cnt_undone,
    output logic [CNT_W-1:0]  cnt_undone_real
);
    hb_rec_t                   push_rec, oldest, newest;
    logic                      push_en, pop_new, pop_old, empty;
    logic [EV_N-1:0]           events;
    logic [EV_N-1:0][CNT_W-1:0] counts;

    // a placeholder keeps only its sequence number
    always_comb begin
        push_rec     = '0;
        push_rec.ph  = push_placeholder;
        push_rec.seq = push_seq;
        if (!push_placeholder) begin
            push_rec.arch = push_arch;
            push_rec.newp = push_new_phys;
            push_rec.oldp = push_old_phys;
        end
    end

    hb_ring #(.DEPTH(DEPTH)) ring_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (push_en),
        .push_rec (push_rec),
        .pop_new  (pop_new),
        .pop_old  (pop_old),
        .oldest   (oldest),
        .newest   (newest),
        .full     (full),
        .empty    (empty)
    );

    hb_ctrl ctrl_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .push_valid       (push_valid),
        .push_placeholder (push_placeholder),
        .squash_valid     (squash_valid),
        .squash_seq       (squash_seq),
        .commit_valid     (commit_valid),
        .commit_seq       (commit_seq),
        .full             (full),
        .empty            (empty),
        .oldest           (oldest),
        .newest           (newest),
        .push_en          (push_en),
        .pop_new          (pop_new),
        .pop_old          (pop_old),
        .busy             (busy),
        .map_wr_valid     (map_wr_valid),
        .map_wr_arch      (map_wr_arch),
        .map_wr_phys      (map_wr_phys),
        .free_valid       (free_valid),
        .free_phys        (free_phys),
        .events           (events)
    );

    hb_counters #(.CNT_W(CNT_W)) cnt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .events (events),
        .counts (counts)
    );

    assign cnt_placeholder = counts[EV_PH];
    assign cnt_committed   = counts[EV_COMMIT];
    assign cnt_undone      = counts[EV_UNDO];
    assign cnt_undone_real = counts[EV_UNDO_RL];

    // R4: a restore and its free always travel together
    a_r4_pair: assert property (@(posedge clk) disable iff (!rst_n)
        map_wr_valid |-> free_valid);

    // R10: nothing is appended while the buffer is full
    a_r10_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_en && full));
endmodule

// File: tb/rename_history_tb_top.sv
module rename_history_tb_top;
    import hb_pkg::*;

    localparam int DEPTH = 8;
    localparam int CNT_W = 16;
    localparam int NTAB  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_valid = 1'b0, push_placeholder = 1'b0;
    logic [SEQ_W-1:0]  push_seq = '0;
    logic [ARCH_W-1:0] push_arch = '0;
    logic [PHYS_W-1:0] push_new_phys = '0, push_old_phys = '0;
    logic              squash_valid = 1'b0, commit_valid = 1'b0;
    logic [SEQ_W-1:0]  squash_seq = '0, commit_seq = '0;
    logic              map_wr_valid, free_valid, full, busy;
    logic [ARCH_W-1:0] map_wr_arch;
    logic [PHYS_W-1:0] map_wr_phys, free_phys;
    logic [CNT_W-1:0]  cnt_placeholder, cnt_committed, cnt_undone, cnt_undone_real;

    always #10 clk = ~clk;  // 50 MHz

    rename_history #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (.*);

    // stimulus table: {placeholder, seq, arch, new phys, old phys}
    localparam hb_rec_t PUSH_TAB [NTAB] = '{
        '{1'b0, 16'd1, 5'd3, 7'd33, 7'd3},
        '{1'b1, 16'd2, 5'd0, 7'd0,  7'd0},
        '{1'b0, 16'd3, 5'd5, 7'd34, 7'd5},
        '{1'b0, 16'd3, 5'd6, 7'd35, 7'd6},
        '{1'b0, 16'd4, 5'd3, 7'd36, 7'd33},
        '{1'b1, 16'd5, 5'd0, 7'd0,  7'd0},
        '{1'b0, 16'd6, 5'd7, 7'd37, 7'd7},
        '{1'b0, 16'd7, 5'd5, 7'd38, 7'd34}
    };

    int n_tests = 0;
    int n_fail  = 0;

    hb_rec_t model[$];
    int exp_map[$], exp_free[$], got_map[$], got_free[$];
    int e_ph = 0, e_cm = 0, e_un = 0, e_ur = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (map_wr_valid) got_map.push_back({map_wr_arch, map_wr_phys});
            if (free_valid)   got_free.push_back(int'(free_phys));
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    task automatic wait_idle();
        int guard = 0;
        @(negedge clk);
        while (busy && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic do_push(input hb_rec_t r, input bit with_squash, input logic [SEQ_W-1:0] s);
        push_valid = 1'b1; push_placeholder = r.ph; push_seq = r.seq;
        push_arch = r.arch; push_new_phys = r.newp; push_old_phys = r.oldp;
        squash_valid = with_squash; squash_seq = s;
        if (!with_squash && model.size() < DEPTH) begin
            model.push_back(r.ph ? hb_rec_t'{1'b1, r.seq, 5'd0, 7'd0, 7'd0} : r);
            if (r.ph) e_ph++;
        end
        @(negedge clk);
        push_valid = 1'b0; squash_valid = 1'b0;
    endtask

    function automatic void model_squash(input int s);
        while (model.size() > 0 && int'(model[$].seq) > s) begin
            hb_rec_t r = model.pop_back();
            e_un++;
            if (!r.ph) begin
                exp_map.push_back({r.arch, r.oldp});
                exp_free.push_back(int'(r.newp));
                e_ur++;
            end
        end
    endfunction

    function automatic void model_commit(input int c, input int max_pops);
        int n = 0;
        if (model.size() == 0 || int'(model[0].seq) > c) return;
        while (model.size() > 0 && int'(model[0].seq) <= c && n < max_pops) begin
            hb_rec_t r = model.pop_front();
            n++;
            if (!r.ph) begin
                exp_free.push_back(int'(r.oldp));
                e_cm++;
            end
        end
    endfunction

    task automatic do_squash(input int s);
        squash_valid = 1'b1; squash_seq = SEQ_W'(s);
        model_squash(s);
        @(negedge clk);
        squash_valid = 1'b0;
        wait_idle();
    endtask

    task automatic do_commit(input int c);
        commit_valid = 1'b1; commit_seq = SEQ_W'(c);
        model_commit(c, 1 << 20);
        @(negedge clk);
        commit_valid = 1'b0;
        wait_idle();
    endtask

    task automatic compare(input string req);
        check(got_map.size() == exp_map.size(), {req, " restore count"}, got_map.size(), exp_map.size());
        for (int i = 0; i < exp_map.size() && i < got_map.size(); i++)
            check(got_map[i] == exp_map[i], {req, " restore value"}, got_map[i], exp_map[i]);
        check(got_free.size() == exp_free.size(), {req, " free count"}, got_free.size(), exp_free.size());
        for (int i = 0; i < exp_free.size() && i < got_free.size(); i++)
            check(got_free[i] == exp_free[i], {req, " free value"}, got_free[i], exp_free[i]);
        check(int'(cnt_placeholder) == e_ph, "R8 placeholder counter", int'(cnt_placeholder), e_ph);
        check(int'(cnt_committed) == e_cm, "R8 committed counter", int'(cnt_committed), e_cm);
        check(int'(cnt_undone) == e_un, "R8 undone counter", int'(cnt_undone), e_un);
        check(int'(cnt_undone_real) == e_ur, "R8 undone real counter", int'(cnt_undone_real), e_ur);
        got_map.delete(); got_free.delete(); exp_map.delete(); exp_free.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!full && !busy, "R1 flags", int'({full, busy}), 0);
        check(!map_wr_valid && !free_valid, "R1 commands", int'({map_wr_valid, free_valid}), 0);
        compare("R1");

        // R2: table of appends, placeholders and multi-destination entries
        for (int i = 0; i < NTAB; i++) do_push(PUSH_TAB[i], 1'b0, '0);
        @(negedge clk);
        check(!busy && !free_valid, "R2 appends issue no command", int'(busy), 0);
        compare("R2");

        // R5: retire through seq 3 (two entries share seq 3, one placeholder)
        do_commit(3);
        compare("R5");

        // R6: target older than the oldest entry
        do_commit(2);
        check(!busy, "R6 busy stays low", int'(busy), 0);
        compare("R6");

        // R3 R4: rollback to seq 4 removes 7, 6 and placeholder 5
        do_squash(4);
        compare("R3 R4");

        // R3: rollback to 0 removes the survivor
        do_squash(0);
        compare("R3");

        // R7: rollback on an empty buffer
        do_squash(0);
        compare("R7");
        // R6: retirement on an empty buffer
        do_commit(100);
        compare("R6 empty");

        // R10: fill, then one more append must be dropped
        for (int i = 0; i < DEPTH; i++)
            do_push(hb_rec_t'{1'b0, SEQ_W'(20 + i), ARCH_W'(i), PHYS_W'(40 + i), PHYS_W'(60 + i)}, 1'b0, '0);
        check(full, "R10 full at DEPTH", int'(full), 1);
        do_push(hb_rec_t'{1'b0, 16'd28, 5'd9, 7'd99, 7'd98}, 1'b0, '0);
        do_commit(100);
        check(!full, "R10 full clears", int'(full), 0);
        compare("R10 full drop");

        // R10: an append in the same cycle as a rollback request is dropped
        do_push(hb_rec_t'{1'b0, 16'd30, 5'd1, 7'd70, 7'd71}, 1'b0, '0);
        do_push(hb_rec_t'{1'b0, 16'd31, 5'd2, 7'd72, 7'd73}, 1'b0, '0);
        model_squash(30);
        do_push(hb_rec_t'{1'b0, 16'd32, 5'd4, 7'd74, 7'd75}, 1'b1, 16'd30);
        wait_idle();
        do_commit(100);
        compare("R10 squash drop");

        // R9: rollback aborts a retirement after exactly one removal
        for (int i = 0; i < 4; i++)
            do_push(hb_rec_t'{1'b0, SEQ_W'(40 + i), ARCH_W'(10 + i), PHYS_W'(80 + i), PHYS_W'(90 + i)}, 1'b0, '0);
        commit_valid = 1'b1; commit_seq = 16'd43;
        model_commit(43, 1);
        @(negedge clk);
        commit_valid = 1'b0;
        @(negedge clk);
        squash_valid = 1'b1; squash_seq = 16'd41;
        model_squash(41);
        @(negedge clk);
        squash_valid = 1'b0;
        wait_idle();
        compare("R9");
        do_commit(100);
        compare("R9 survivor");

        finish_run();
    end
endmodule